// File: doc/BRIEF.md
# Serial Configuration Port with Control-Mode Entry

This block is the configuration port of a data-converter style device. A host reaches a small bank of byte-wide setting registers over a three-wire serial link. The link has an active-low select, a serial clock and one shared data line. The data line is split at the block boundary into an input, an output and an output enable, so a pad cell can make it bidirectional. Every access opens with a 16-bit command word. The command carries a direction flag, a 2-bit length code and a 13-bit start address. One or more data bytes follow it, and each byte goes to the next address in turn.

The block also governs how the device leaves its power-up pin-control state. The first time select is asserted, the device moves for good into serial-control mode. At that moment the block samples the data line and the clock line. The data line sets the output-standard bit and the clock line sets the default sample-format code. After that, only serial writes change these settings, and only a serial write can select Gray coding. All pins are brought into the system clock domain through synchronisers and edge detectors, so the serial clock must be several times slower than the system clock.

Top module: `spi_cfg_port`

## Requirements
- R1: After reset, `serial_mode` is 0, `out_lvds` is 0, `data_fmt` is 00 and `spi_sdio_oe` is 0.
- R2: The first falling edge of `spi_cs_n` sets `serial_mode` to 1. At that edge, the `spi_sdio_i` level is copied into `out_lvds` (1 means LVDS DDR). The `spi_sclk` level selects `data_fmt`: 0 gives 00 (offset binary) and 1 gives 01 (two's complement). Later select edges capture nothing, and `serial_mode` never returns to 0.
- R3: The command is 16 bits, sampled MSB first on rising `spi_sclk`. Bit 15 is the direction (1 means read). Bits 14:13 are the length code. Bits 12:0 are the start address.
- R4: On a write, each data byte is sampled MSB first. The first byte goes to the start address, and each following byte goes to the next higher address.
- R5: Length codes 00, 01 and 10 allow 1, 2 and 3 data bytes. Bytes beyond that count are not written. On a read, `spi_sdio_oe` is 0 for those extra bytes.
- R6: Length code 11 keeps moving through addresses, one per byte, until select rises.
- R7: On a read, `spi_sdio_o` starts carrying data at the falling `spi_sclk` edge that follows the last command bit. Data goes out MSB first, from successive addresses. `spi_sdio_oe` returns to 0 once select rises.
- R8: If select rises partway through a data byte, that byte is not written.
- R9: Addresses 8 and above hold no register. They read back as 0x00, and writes to them change nothing.
- R10: Address 1 is the output-control register. Bit 0 drives `out_lvds` and bits 2:1 drive `data_fmt`. The code 10 (Gray) is reachable only through a write to this register.
- R11: `spi_sdio_oe` stays 0 during the command phase and during the data phase of a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Serial select, active low |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_sdio_i | input | 1 | Data line, level seen at the pad |
| spi_sdio_o | output | 1 | Data line value driven during reads |
| spi_sdio_oe | output | 1 | Drive enable for the data line |
| serial_mode | output | 1 | 1 once serial-control mode is entered |
| out_lvds | output | 1 | Output standard: 1 LVDS DDR, 0 CMOS |
| data_fmt | output | 2 | Sample format: 00 offset binary, 01 two's complement, 10 Gray |

## Verification
The bench first checks the pin-sampled defaults at mode entry. It then opens a second transfer with the opposite pin levels. A design that re-captures on every select edge would flip the output standard and the format at that point. A write table covers every length code with surplus bytes. An over-eager counter shows up as corruption in the neighbouring register, and a streaming write that crosses the top of the bank shows up as stray writes past the end. A write cut off after five bits checks that a byte left partial is dropped and not committed. Read tests sample the line on the first data bit and check the release when select rises. A design off by one edge would return a shifted byte, and one that never lets go of the line would leave the enable stuck high.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_INSTR = 2'd1,
        PH_DATA  = 2'd2
    } spi_phase_e;

    localparam logic [1:0] LEN_STREAM = 2'b11;
    localparam logic [1:0] FMT_OFFSET = 2'b00;
    localparam logic [1:0] FMT_TWOS   = 2'b01;
    localparam logic [1:0] FMT_GRAY   = 2'b10;
    localparam int unsigned OUTCTL_IDX = 1;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int unsigned WIDTH   = 3,
    parameter int unsigned STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] lvl_o,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);
    logic [WIDTH-1:0] stg_d [STAGES];
    logic [WIDTH-1:0] stg_q [STAGES];
    logic [WIDTH-1:0] prev_d, prev_q;

    always_comb begin
        stg_d[0] = pin_i;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
        prev_d = stg_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= RST_VAL;
            end
            prev_q <= RST_VAL;
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= stg_d[i];
            end
            prev_q <= prev_d;
        end
    end

    assign lvl_o  = stg_q[STAGES-1];
    assign rise_o = stg_q[STAGES-1] & ~prev_q;
    assign fall_o = ~stg_q[STAGES-1] & prev_q;
endmodule

// File: rtl/spi_serial_engine.sv
module spi_serial_engine
    import spi_cfg_pkg::*;
#(
    parameter int unsigned ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_fall,
    input  logic              cs_rise,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              sdi,
    input  logic [7:0]        rdata,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wdata,
    output logic              sdo,
    output logic              sdo_oe
);
    localparam int unsigned CMD_W = 16;
    localparam int unsigned SH_W  = CMD_W - 1;

    typedef struct packed {
        spi_phase_e        phase;
        logic [3:0]        bcnt;
        logic [2:0]        dbit;
        logic [1:0]        nb;
        logic              rw;
        logic [1:0]        len;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] waddr;
        logic [SH_W-1:0]   sh;
        logic [7:0]        tx;
        logic              sdo;
        logic              oe;
        logic              wr_en;
        logic [7:0]        wdata;
    } eng_t;

    eng_t st_d, st_q;
    logic in_count;

    always_comb begin
        st_d       = st_q;
        st_d.wr_en = 1'b0;
        in_count   = (st_q.len == LEN_STREAM) || (st_q.nb <= st_q.len);

        if (cs_fall) begin
            st_d.phase = PH_INSTR;
            st_d.bcnt  = '0;
            st_d.dbit  = '0;
            st_d.nb    = '0;
            st_d.oe    = 1'b0;
        end else if (cs_rise) begin
            st_d.phase = PH_IDLE;
            st_d.oe    = 1'b0;
        end else if (st_q.phase == PH_INSTR) begin
            if (sclk_rise) begin
                st_d.sh = {st_q.sh[SH_W-2:0], sdi};
                if (st_q.bcnt == 4'd15) begin
                    st_d.rw    = st_q.sh[SH_W-1];
                    st_d.len   = st_q.sh[SH_W-2:SH_W-3];
                    st_d.addr  = {st_q.sh[ADDR_W-2:0], sdi};
                    st_d.phase = PH_DATA;
                    st_d.dbit  = '0;
                    st_d.nb    = '0;
                end else begin
                    st_d.bcnt = st_q.bcnt + 4'd1;
                end
            end
        end else if (st_q.phase == PH_DATA) begin
            if (sclk_rise) begin
                st_d.sh   = {st_q.sh[SH_W-2:0], sdi};
                st_d.dbit = st_q.dbit + 3'd1;
                if (st_q.dbit == 3'd7 && in_count) begin
                    if (!st_q.rw) begin
                        st_d.wr_en = 1'b1;
                        st_d.waddr = st_q.addr;
                        st_d.wdata = {st_q.sh[6:0], sdi};
                    end
                    st_d.addr = st_q.addr + 1'b1;
                    if (st_q.nb != 2'd3) begin
                        st_d.nb = st_q.nb + 2'd1;
                    end
                end
            end else if (sclk_fall && st_q.rw) begin
                if (in_count) begin
                    st_d.oe = 1'b1;
                    if (st_q.dbit == 3'd0) begin
                        st_d.sdo = rdata[7];
                        st_d.tx  = {rdata[6:0], 1'b0};
                    end else begin
                        st_d.sdo = st_q.tx[7];
                        st_d.tx  = {st_q.tx[6:0], 1'b0};
                    end
                end else begin
                    st_d.oe = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_addr = st_q.addr;
    assign wr_en   = st_q.wr_en;
    assign wr_addr = st_q.waddr;
    assign wdata   = st_q.wdata;
    assign sdo     = st_q.sdo;
    assign sdo_oe  = st_q.oe;

    assert_release_on_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise |=> !sdo_oe);
    assert_quiet_outside_data_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase != PH_DATA) |-> !sdo_oe);
    assert_no_drive_on_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.rw && st_q.phase == PH_DATA) |-> !sdo_oe);
    assert_write_only_dir_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !st_q.rw);
    assert_addr_steps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (st_q.addr == wr_addr + 1'b1));
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
    import spi_cfg_pkg::*;
#(
    parameter int unsigned ADDR_W   = 13,
    parameter int unsigned NUM_REGS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              boot_ld,
    input  logic              boot_lvds,
    input  logic              boot_twos,
    output logic [7:0]        rdata,
    output logic              out_lvds,
    output logic [1:0]        data_fmt
);
    localparam int unsigned IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(NUM_REGS);

    logic [7:0] regs_d [NUM_REGS];
    logic [7:0] regs_q [NUM_REGS];
    logic       wr_hit, rd_hit;

    always_comb begin
        wr_hit = wr_en && (wr_addr < TOP_ADDR);
        rd_hit = rd_addr < TOP_ADDR;
        for (int i = 0; i < NUM_REGS; i++) begin
            regs_d[i] = regs_q[i];
            if (wr_hit && wr_addr[IDX_W-1:0] == IDX_W'(i)) begin
                regs_d[i] = wdata;
            end
        end
        if (boot_ld) begin
            regs_d[OUTCTL_IDX] = {5'b0, (boot_twos ? FMT_TWOS : FMT_OFFSET), boot_lvds};
        end
        rdata = rd_hit ? regs_q[rd_addr[IDX_W-1:0]] : 8'h00;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                regs_q[i] <= 8'h00;
            end
        end else begin
            for (int i = 0; i < NUM_REGS; i++) begin
                regs_q[i] <= regs_d[i];
            end
        end
    end

    assign out_lvds = regs_q[OUTCTL_IDX][0];
    assign data_fmt = regs_q[OUTCTL_IDX][2:1];

    assert_boot_never_gray_R10: assert property (@(posedge clk) disable iff (!rst_n)
        boot_ld |=> (data_fmt != FMT_GRAY));
    assert_oob_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !(wr_addr < TOP_ADDR) && !boot_ld) |=> ($stable(out_lvds) && $stable(data_fmt)));
endmodule

// File: rtl/spi_cfg_port.sv
module spi_cfg_port
    import spi_cfg_pkg::*;
#(
    parameter int unsigned ADDR_W      = 13,
    parameter int unsigned NUM_REGS    = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       spi_cs_n,
    input  logic       spi_sclk,
    input  logic       spi_sdio_i,
    output logic       spi_sdio_o,
    output logic       spi_sdio_oe,
    output logic       serial_mode,
    output logic       out_lvds,
    output logic [1:0] data_fmt
);
    localparam int unsigned PIN_W = 3;
    localparam int unsigned P_CS = 2;
    localparam int unsigned P_CK = 1;
    localparam int unsigned P_DI = 0;

    logic [PIN_W-1:0] pin_lvl, pin_rise, pin_fall;
    logic             cs_fall, cs_rise, boot_ld;
    logic             mode_d, mode_q;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [7:0]       rdata, wdata;
    logic             wr_en;

    spi_pin_sync #(
        .WIDTH  (PIN_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i ({spi_cs_n, spi_sclk, spi_sdio_i}),
        .lvl_o (pin_lvl),
        .rise_o(pin_rise),
        .fall_o(pin_fall)
    );

    assign cs_fall = pin_fall[P_CS];
    assign cs_rise = pin_rise[P_CS];

    always_comb begin
        mode_d  = mode_q;
        boot_ld = cs_fall && !mode_q;
        if (boot_ld) begin
            mode_d = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
        end else begin
            mode_q <= mode_d;
        end
    end

    spi_serial_engine #(
        .ADDR_W(ADDR_W)
    ) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_fall  (cs_fall),
        .cs_rise  (cs_rise),
        .sclk_rise(pin_rise[P_CK]),
        .sclk_fall(pin_fall[P_CK]),
        .sdi      (pin_lvl[P_DI]),
        .rdata    (rdata),
        .rd_addr  (rd_addr),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wdata    (wdata),
        .sdo      (spi_sdio_o),
        .sdo_oe   (spi_sdio_oe)
    );

    spi_reg_bank #(
        .ADDR_W  (ADDR_W),
        .NUM_REGS(NUM_REGS)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wdata    (wdata),
        .rd_addr  (rd_addr),
        .boot_ld  (boot_ld),
        .boot_lvds(pin_lvl[P_DI]),
        .boot_twos(pin_lvl[P_CK]),
        .rdata    (rdata),
        .out_lvds (out_lvds),
        .data_fmt (data_fmt)
    );

    assign serial_mode = mode_q;

    assert_mode_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        serial_mode |=> serial_mode);
    assert_mode_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall |=> serial_mode);
endmodule

// File: tb/spi_cfg_port_tb.sv
module spi_cfg_port_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 6;
    localparam int NV = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
    logic sdo, oe, smode, lvds;
    logic [1:0] fmt;
    int n_chk = 0, n_bad = 0;
    logic [7:0] mdl [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_cfg_port u_dut (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sclk(sclk),
        .spi_sdio_i(sdi), .spi_sdio_o(sdo), .spi_sdio_oe(oe),
        .serial_mode(smode), .out_lvds(lvds), .data_fmt(fmt)
    );

    // {addr[12:0], len[1:0], bytes sent[2:0], data bytes MSB first[31:0]}
    localparam logic [49:0] VEC [NV] = '{
        {13'h0000, 2'd0, 3'd1, 32'hAA00_0000},
        {13'h0002, 2'd1, 3'd2, 32'h1234_0000},
        {13'h0004, 2'd2, 3'd3, 32'h5678_9A00},
        {13'h0005, 2'd0, 3'd3, 32'hC3EE_DD00},
        {13'h0006, 2'd3, 3'd4, 32'h6177_8899},
        {13'h0001, 2'd0, 3'd1, 32'h0400_0000},
        {13'h1F00, 2'd1, 3'd2, 32'h5A5A_0000},
        {13'h0000, 2'd1, 3'd3, 32'h4403_FF00}
    };

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic spi_begin(input logic d_lvl, input logic c_lvl);
        sclk = c_lvl; sdi = d_lvl;
        wclk(HALF);
        cs_n = 1'b0;
        wclk(HALF);
    endtask

    task automatic spi_end();
        sclk = 1'b0;
        wclk(HALF);
        cs_n = 1'b1;
        wclk(2*HALF);
    endtask

    task automatic xbit(input logic b, output logic r, output logic e);
        sclk = 1'b0; sdi = b;
        wclk(HALF);
        r = sdo; e = oe;
        sclk = 1'b1;
        wclk(HALF);
    endtask

    task automatic xbyte(input logic [7:0] b, output logic [7:0] r, output logic any_oe, output logic all_oe);
        logic rb, eb;
        any_oe = 1'b0; all_oe = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            xbit(b[i], rb, eb);
            r[i] = rb;
            any_oe |= eb; all_oe &= eb;
        end
    endtask

    task automatic send_cmd(input logic rw, input logic [1:0] len, input logic [12:0] a, output logic any_oe);
        logic [15:0] w;
        logic [7:0] r;
        logic a1, a2, x1, x2;
        w = {rw, len, a};
        xbyte(w[15:8], r, a1, x1);
        xbyte(w[7:0], r, a2, x2);
        any_oe = a1 | a2;
    endtask

    task automatic rd_burst(input logic [12:0] a, input string tag);
        logic [7:0] r;
        logic ao, al;
        send_cmd(1'b1, 2'd3, a, ao);
        check({31'd0, ao}, 32'd0, {tag, " R11 no drive in command"});
        for (int i = 0; i < 4; i++) begin
            logic [7:0] ex;
            ex = ((a + 13'(i)) < 13'd8) ? mdl[a[2:0] + 3'(i)] : 8'h00;
            xbyte(8'h00, r, ao, al);
            check({24'd0, r}, {24'd0, ex}, {tag, " R7 R6 R9 readback"});
        end
        spi_end();
        check({31'd0, oe}, 32'd0, {tag, " R7 release"});
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [7:0] r;
        logic ao, al;
        for (int i = 0; i < 8; i++) mdl[i] = 8'h00;
        wclk(4);
        // R1 reset state
        check({31'd0, smode}, 32'd0, "R1 serial_mode");
        check({31'd0, lvds}, 32'd0, "R1 out_lvds");
        check({30'd0, fmt}, 32'd0, "R1 data_fmt");
        check({31'd0, oe}, 32'd0, "R1 sdio_oe");
        rst_n = 1'b1;
        wclk(4);
        check({31'd0, smode}, 32'd0, "R1 still pin mode before select");

        // R2 mode entry: sdio=1 -> LVDS, sclk=1 -> two's complement
        spi_begin(1'b1, 1'b1);
        spi_end();
        mdl[1] = 8'h03;
        check({31'd0, smode}, 32'd1, "R2 serial_mode set");
        check({31'd0, lvds}, 32'd1, "R2 captured lvds");
        check({30'd0, fmt}, 32'd1, "R2 captured twos");
        spi_begin(1'b0, 1'b0);
        spi_end();
        check({31'd0, lvds}, 32'd1, "R2 no recapture lvds");
        check({30'd0, fmt}, 32'd1, "R2 no recapture fmt");

        // Table walk: writes per R3 R4 R5 R6 R9, readback, output control R10
        for (int v = 0; v < NV; v++) begin
            logic [12:0] a;
            logic [1:0]  ln;
            logic [2:0]  ns;
            logic [31:0] dt;
            logic        oe_seen;
            {a, ln, ns, dt} = VEC[v];
            spi_begin(1'b0, 1'b0);
            send_cmd(1'b0, ln, a, oe_seen);
            for (int i = 0; i < int'(ns); i++) begin
                logic [7:0] b;
                b = dt[31-8*i -: 8];
                xbyte(b, r, ao, al);
                oe_seen |= ao;
                if ((ln == 2'd3 || i <= int'(ln)) && (a + 13'(i)) < 13'd8)
                    mdl[a[2:0] + 3'(i)] = b;
            end
            spi_end();
            check({31'd0, oe_seen}, 32'd0, $sformatf("R11 write vec %0d", v));
            check({31'd0, lvds}, {31'd0, mdl[1][0]}, $sformatf("R10 lvds vec %0d", v));
            check({30'd0, fmt}, {30'd0, mdl[1][2:1]}, $sformatf("R10 fmt vec %0d", v));
            spi_begin(1'b0, 1'b0);
            rd_burst(a, $sformatf("vec %0d", v));
        end

        // R10 gray selected by write, then restored
        spi_begin(1'b0, 1'b0);
        send_cmd(1'b0, 2'd0, 13'd1, ao);
        xbyte(8'h04, r, ao, al);
        spi_end();
        mdl[1] = 8'h04;
        check({30'd0, fmt}, 32'd2, "R10 gray via write");

        // R8 partial byte dropped
        spi_begin(1'b0, 1'b0);
        send_cmd(1'b0, 2'd0, 13'd3, ao);
        for (int i = 0; i < 5; i++) xbit(1'b1, r[0], ao);
        spi_end();
        spi_begin(1'b0, 1'b0);
        rd_burst(13'd2, "R8 partial");

        // R7 first data bit timing, R5 read beyond count releases
        spi_begin(1'b0, 1'b0);
        send_cmd(1'b1, 2'd0, 13'd4, ao);
        xbit(1'b0, r[0], ao);
        check({31'd0, ao}, 32'd1, "R7 drive on first data bit");
        check({31'd0, r[0]}, {31'd0, mdl[4][7]}, "R7 msb first");
        for (int i = 6; i >= 0; i--) xbit(1'b0, r[0], ao);
        xbyte(8'h00, r, ao, al);
        check({31'd0, ao}, 32'd0, "R5 released beyond count");
        spi_end();
        check({31'd0, oe}, 32'd0, "R7 released after select");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule